// File: doc/BRIEF.md
# Quad-float to unsigned 64-bit truncating converter

This unit takes a 128-bit IEEE binary128 operand and turns it into an unsigned 64-bit integer by discarding the fractional part, which is rounding toward zero. The operand layout is sign in bit 127, a 15-bit biased exponent (bias 16383) in bits 126:112 and a 112-bit fraction in bits 111:0. An all-ones exponent marks infinity or NaN, and a NaN with fraction bit 111 set is quiet. The 64-bit integer is returned in the low half of a 128-bit result whose high half is always zero.

The input is sampled on a valid strobe and every output is registered, so results appear one clock later. Values that cannot be represented saturate or clear, and status outputs report a signaling-NaN invalid, a conversion invalid, an inexact conversion, and the two fraction indications (rounded and inexact) that are forced low whenever an invalid occurs. The `invalid_en` input models an enabled invalid trap. When it is set and the operation is invalid, the write-enable output drops so that the destination is left untouched.

Top module: `quad_to_u64_trunc`

## Requirements
- R1: All outputs are registered. One clock after `in_valid` is high, `out_valid` is 1 and the outputs carry the conversion of the sampled operand. One clock after `in_valid` is low, every output is 0. While `rst_n` is low, every output is 0.
- R2: A NaN (exponent bits 126:112 all ones, fraction bits 111:0 nonzero) gives result 0 with `flag_cvi` = 1. `flag_snan` = 1 only when fraction bit 111 is 0, which marks a signaling NaN.
- R3: Infinity (exponent all ones, fraction zero) raises `flag_cvi`. With sign bit 127 = 0 the result is 0xFFFF_FFFF_FFFF_FFFF, and with sign 1 the result is 0.
- R4: A zero of either sign (bits 126:0 all zero) gives result 0 and leaves every flag low.
- R5: A positive finite value with unbiased exponent e in 0..63 gives floor(value). `flag_inexact` is 1 exactly when the discarded fraction bits are nonzero.
- R6: A positive finite value with e >= 64 (value >= 2^64) saturates to 0xFFFF_FFFF_FFFF_FFFF and raises `flag_cvi`.
- R7: A negative finite value of magnitude >= 1 gives 0 and raises `flag_cvi`.
- R8: A nonzero finite value of magnitude below 1 of either sign, subnormals included, gives 0 with `flag_inexact` = 1 and no invalid flag.
- R9: Result bits 127:64 are always 0, and the integer sits in bits 63:0.
- R10: `out_write_en` is 1 after a valid input unless `invalid_en` was 1 and the conversion raised `flag_cvi` or `flag_snan`.
- R11: `flag_fr` is always 0, because truncation never increments. `flag_fi` equals `flag_inexact` with no invalid flag raised.
- R12: `flag_inexact` is never raised together with `flag_cvi`, and `flag_snan` is never raised without `flag_cvi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 128 | binary128 source operand |
| invalid_en | input | 1 | Invalid-trap enable; suppresses the write on an invalid |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_result | output | 128 | Zero-extended 64-bit integer |
| out_write_en | output | 1 | Destination write permitted |
| flag_snan | output | 1 | Signaling-NaN invalid |
| flag_cvi | output | 1 | Conversion invalid |
| flag_inexact | output | 1 | Nonzero fraction bits discarded |
| flag_fr | output | 1 | Fraction rounded (magnitude incremented) |
| flag_fi | output | 1 | Fraction inexact, gated by the absence of invalid |

## Verification
The assertions run on every cycle. They cover the one-cycle valid latency, the NaN, infinity and zero results keyed off the sampled operand fields, the zero high half, the exclusion rules among the flags, and write suppression under `invalid_en`. Only the bench scenarios can show the truncated integer values, the exact inexact boundary, the 2^64 saturation edge, negative values around magnitude one, and subnormals. The bench checks these against a reference model that rebuilds the integer by shifting left by the exponent.

// File: rtl/q2u_pkg.sv
package q2u_pkg;

  // operand classes seen by the result selector
  typedef enum logic [2:0] {
    QC_ZERO,
    QC_TINY,
    QC_NORMAL,
    QC_INF,
    QC_QNAN,
    QC_SNAN
  } qcls_e;

  typedef struct packed {
    logic snan;
    logic cvi;
    logic xx;
    logic inc;
  } cvt_flags_t;

endpackage

// File: rtl/q2u_classify.sv
module q2u_classify
  import q2u_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 112
) (
  input  logic [EXP_W-1:0]  exp_f,
  input  logic [FRAC_W-1:0] frac_f,
  output qcls_e             cls
);

  logic exp_max;
  logic exp_min;
  logic frac_nz;

  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    if (exp_max) begin
      if (!frac_nz)                cls = QC_INF;
      else if (frac_f[FRAC_W-1])   cls = QC_QNAN;
      else                         cls = QC_SNAN;
    end else if (exp_min) begin
      cls = frac_nz ? QC_TINY : QC_ZERO;
    end else begin
      cls = QC_NORMAL;
    end
  end

endmodule

// File: rtl/q2u_trunc.sv
module q2u_trunc #(
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 112,
  parameter int INT_W  = 64
) (
  input  logic [EXP_W-1:0]  exp_f,
  input  logic [FRAC_W-1:0] frac_f,
  output logic [INT_W-1:0]  int_val,
  output logic              below_one,
  output logic              too_big,
  output logic              lost_bits
);

  localparam int SIG_W = FRAC_W + 1;
  localparam int SH_W  = $clog2(SIG_W);
  localparam logic [EXP_W-1:0] BIAS    = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [EXP_W-1:0] EXP_SAT = BIAS + EXP_W'(INT_W);

  logic [SIG_W-1:0] sig;
  logic [EXP_W-1:0] e_unb;
  logic [SH_W-1:0]  shamt;

  // right shift of the significand keeps the integer part
  function automatic logic [INT_W-1:0] int_part(input logic [SIG_W-1:0] s,
                                                 input logic [SH_W-1:0]  sh);
    return INT_W'(s >> sh);
  endfunction

  // OR of every bit pushed out below the binary point
  function automatic logic dropped(input logic [SIG_W-1:0] s,
                                   input logic [SH_W-1:0]  sh);
    logic [SIG_W-1:0] mask;
    mask = ~({SIG_W{1'b1}} << sh);
    return |(s & mask);
  endfunction

  assign sig       = {1'b1, frac_f};
  assign below_one = (exp_f < BIAS);
  assign too_big   = (exp_f >= EXP_SAT);
  assign e_unb     = exp_f - BIAS;
  // only meaningful when 0 <= e < INT_W, so the narrowing is safe
  assign shamt     = SH_W'(FRAC_W) - SH_W'(e_unb);
  assign int_val   = int_part(sig, shamt);
  assign lost_bits = dropped(sig, shamt);

endmodule

// File: rtl/q2u_select.sv
module q2u_select
  import q2u_pkg::*;
#(
  parameter int INT_W = 64
) (
  input  qcls_e             cls,
  input  logic              sign,
  input  logic [INT_W-1:0]  int_val,
  input  logic              below_one,
  input  logic              too_big,
  input  logic              lost_bits,
  output logic [INT_W-1:0]  res,
  output cvt_flags_t        flags
);

  always_comb begin
    res   = '0;
    flags = '0;
    unique case (cls)
      QC_QNAN: flags.cvi = 1'b1;
      QC_SNAN: begin
        flags.cvi  = 1'b1;
        flags.snan = 1'b1;
      end
      QC_INF: begin
        flags.cvi = 1'b1;
        res       = sign ? '0 : '1;
      end
      QC_ZERO: res = '0;
      default: begin
        if (below_one) begin
          flags.xx = 1'b1;         // truncates to (signed) zero
        end else if (sign) begin
          flags.cvi = 1'b1;        // integer <= -1
        end else if (too_big) begin
          flags.cvi = 1'b1;
          res       = '1;
        end else begin
          res      = int_val;
          flags.xx = lost_bits;
        end
      end
    endcase
    flags.inc = 1'b0;              // toward-zero never increments
  end

endmodule

// File: rtl/quad_to_u64_trunc.sv
module quad_to_u64_trunc
  import q2u_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 112,
  parameter int INT_W  = 64,
  localparam int QW    = 1 + EXP_W + FRAC_W,
  localparam int RW    = 2 * INT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [QW-1:0] in_operand,
  input  logic          invalid_en,
  output logic          out_valid,
  output logic [RW-1:0] out_result,
  output logic          out_write_en,
  output logic          flag_snan,
  output logic          flag_cvi,
  output logic          flag_inexact,
  output logic          flag_fr,
  output logic          flag_fi
);

  logic              op_sign;
  logic [EXP_W-1:0]  op_exp;
  logic [FRAC_W-1:0] op_frac;
  qcls_e             op_cls;
  logic [INT_W-1:0]  t_int;
  logic              t_below, t_big, t_lost;
  logic [INT_W-1:0]  sel_res;
  cvt_flags_t        sel_flags;
  logic              any_invalid;

  assign op_sign = in_operand[QW-1];
  assign op_exp  = in_operand[QW-2:FRAC_W];
  assign op_frac = in_operand[FRAC_W-1:0];

  q2u_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .exp_f (op_exp),
    .frac_f(op_frac),
    .cls   (op_cls)
  );

  q2u_trunc #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_trunc (
    .exp_f    (op_exp),
    .frac_f   (op_frac),
    .int_val  (t_int),
    .below_one(t_below),
    .too_big  (t_big),
    .lost_bits(t_lost)
  );

  q2u_select #(.INT_W(INT_W)) u_sel (
    .cls      (op_cls),
    .sign     (op_sign),
    .int_val  (t_int),
    .below_one(t_below),
    .too_big  (t_big),
    .lost_bits(t_lost),
    .res      (sel_res),
    .flags    (sel_flags)
  );

  assign any_invalid = sel_flags.cvi | sel_flags.snan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_write_en <= 1'b0;
      flag_snan    <= 1'b0;
      flag_cvi     <= 1'b0;
      flag_inexact <= 1'b0;
      flag_fr      <= 1'b0;
      flag_fi      <= 1'b0;
    end else if (in_valid) begin
      out_valid    <= 1'b1;
      out_result   <= {{(RW-INT_W){1'b0}}, sel_res};
      out_write_en <= ~(invalid_en & any_invalid);
      flag_snan    <= sel_flags.snan;
      flag_cvi     <= sel_flags.cvi;
      flag_inexact <= sel_flags.xx;
      flag_fr      <= sel_flags.inc & ~any_invalid;
      flag_fi      <= sel_flags.xx & ~any_invalid;
    end else begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_write_en <= 1'b0;
      flag_snan    <= 1'b0;
      flag_cvi     <= 1'b0;
      flag_inexact <= 1'b0;
      flag_fr      <= 1'b0;
      flag_fi      <= 1'b0;
    end
  end

endmodule

// File: rtl/q2u_checker.sv
module q2u_checker #(
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 112,
  parameter int INT_W  = 64,
  localparam int QW    = 1 + EXP_W + FRAC_W,
  localparam int RW    = 2 * INT_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [QW-1:0] in_operand,
  input logic          invalid_en,
  input logic          out_valid,
  input logic [RW-1:0] out_result,
  input logic          out_write_en,
  input logic          flag_snan,
  input logic          flag_cvi,
  input logic          flag_inexact,
  input logic          flag_fr,
  input logic          flag_fi
);

  logic op_exp_max;
  logic op_frac_nz;
  assign op_exp_max = &in_operand[QW-2:FRAC_W];
  assign op_frac_nz = |in_operand[FRAC_W-1:0];

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_write_en && !flag_cvi && !flag_fi));

  assert_nan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_exp_max && op_frac_nz) |=> (out_result == '0 && flag_cvi));

  assert_pos_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_exp_max && !op_frac_nz && !in_operand[QW-1])
      |=> (&out_result[INT_W-1:0] && flag_cvi));

  assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_operand[QW-2:0] == '0)
      |=> (out_result == '0 && !flag_cvi && !flag_snan && !flag_inexact));

  assert_high_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_result[RW-1:INT_W] == '0);

  assert_write_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && invalid_en && op_exp_max) |=> !out_write_en);

  assert_fr_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !flag_fr);

  assert_snan_needs_cvi_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_snan |-> flag_cvi);

  assert_xx_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_inexact && flag_cvi));

endmodule

bind quad_to_u64_trunc q2u_checker #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)
) u_chk (.*);

// File: tb/quad_to_u64_trunc_tb.sv
module quad_to_u64_trunc_tb;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_operand = '0;
  logic         invalid_en = 1'b0;
  logic         out_valid, out_write_en;
  logic [127:0] out_result;
  logic         flag_snan, flag_cvi, flag_inexact, flag_fr, flag_fi;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // pending expectation for the next sampled cycle
  logic [127:0] e_res;
  logic [6:0]   e_bits;   // {valid, wr, snan, cvi, xx, fr, fi}
  string        e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_to_u64_trunc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .invalid_en(invalid_en), .out_valid(out_valid), .out_result(out_result),
    .out_write_en(out_write_en), .flag_snan(flag_snan), .flag_cvi(flag_cvi),
    .flag_inexact(flag_inexact), .flag_fr(flag_fr), .flag_fi(flag_fi)
  );

  function automatic logic [127:0] mk(input logic s, input int e, input logic [111:0] f);
    logic [14:0] ex;
    ex = 15'(e + 16383);
    return {s, ex, f};
  endfunction

  // behavioural reference: integer part = (sig << e) >> 112
  task automatic model(input logic [127:0] x, input logic ien, input logic vld,
                       output logic [127:0] r, output logic [6:0] b);
    logic s; logic [14:0] ex; logic [111:0] fr;
    logic [255:0] w; logic [63:0] v; logic cvi, sn, xx;
    int e;
    s = x[127]; ex = x[126:112]; fr = x[111:0];
    v = '0; cvi = 0; sn = 0; xx = 0;
    if (ex == 15'h7fff) begin
      cvi = 1;
      if (fr != 0) sn = ~fr[111];
      else if (!s) v = '1;
    end else if (ex == 0 && fr == 0) begin
      v = '0;
    end else begin
      e = int'(ex) - 16383;
      if (e < 0) xx = 1;
      else if (s) cvi = 1;
      else if (e >= 64) begin v = '1; cvi = 1; end
      else begin
        w = {143'd0, 1'b1, fr} << e;
        v = w[175:112];
        xx = |w[111:0];
      end
    end
    if (!vld) begin r = '0; b = '0; end
    else begin
      r = {64'd0, v};
      b = {1'b1, ~(ien & (cvi | sn)), sn, cvi, xx, 1'b0, xx & ~(cvi | sn)};
    end
  endtask

  task automatic compare();
    logic [6:0] got;
    got = {out_valid, out_write_en, flag_snan, flag_cvi, flag_inexact, flag_fr, flag_fi};
    n_checks++;
    if (got !== e_bits || out_result !== e_res) begin
      n_fail++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               e_tag, out_result, got, e_res, e_bits);
    end
  endtask

  task automatic step(input logic [127:0] x, input logic ien, input logic vld,
                      input string tag);
    @(negedge clk);
    compare();
    in_operand = x; invalid_en = ien; in_valid = vld;
    model(x, ien, vld, e_res, e_bits);
    e_tag = tag;
  endtask

  initial begin
    e_res = '0; e_bits = '0; e_tag = "R1 reset";
    @(negedge clk);
    compare();                              // R1 reset state
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    step(mk(0, 0, 112'd0), 0, 1, "R5 one");
    step(mk(0, 0, {1'b1, 111'd0}), 0, 1, "R5 one-and-half inexact");
    step(mk(0, 63, 112'd0), 0, 1, "R5 two-to-63");
    step(mk(0, 63, {{63{1'b1}}, 49'd0}), 0, 1, "R5 max exact");
    step(mk(0, 63, {{63{1'b1}}, 48'd0, 1'b1}), 0, 1, "R5 max with fraction");
    step(mk(0, 64, 112'd0), 0, 1, "R6 two-to-64");
    step(mk(0, 500, 112'd5), 0, 1, "R6 huge");
    step({1'b0, 15'h7fff, 112'd0}, 0, 1, "R3 +inf");
    step({1'b1, 15'h7fff, 112'd0}, 0, 1, "R3 -inf");
    step({1'b0, 15'h7fff, 1'b1, 111'd3}, 0, 1, "R2 qnan");
    step({1'b1, 15'h7fff, 1'b0, 111'd1}, 0, 1, "R2 snan");
    step(128'd0, 0, 1, "R4 +zero");
    step({1'b1, 127'd0}, 1, 1, "R4 -zero");
    step(mk(1, -1, 112'd0), 0, 1, "R8 -0.5");
    step(mk(0, -20, 112'd7), 0, 1, "R8 +small");
    step({1'b1, 15'd0, 112'd9}, 0, 1, "R8 subnormal");
    step(mk(1, 0, 112'd0), 0, 1, "R7 -1");
    step(mk(1, 40, 112'd1), 0, 1, "R7 -large");
    step(mk(0, 64, 112'd0), 1, 1, "R10 sat suppressed");
    step({1'b0, 15'h7fff, 1'b0, 111'd4}, 1, 1, "R10 snan suppressed");
    step(mk(0, 10, 112'd77), 1, 1, "R10 valid with trap enabled");
    step(mk(0, 5, 112'd0), 0, 0, "R1 idle");
    for (int i = 0; i < 400; i++) begin
      logic [127:0] x;
      x = {$urandom, $urandom, $urandom, $urandom};
      case (i % 4)
        0, 1: x[126:112] = 15'(16380 + $urandom_range(0, 70));
        2: x[126:112] = (i % 8 == 2) ? 15'h7fff : 15'd0;
        default: ;
      endcase
      step(x, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) != 0),
           "R5 R11 R12 random");
    end
    step('0, 0, 0, "R1 flush");
    step('0, 0, 0, "R1 idle");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule